// File: doc/BRIEF.md
# Atomic-Aware Store Issue Gate

This block sits between a core's memory stage and the request port of an L1 data cache, next to an existing store buffer. Ordinary stores from the core pass straight through to the store buffer's push port. Atomic memory operations take another route. The block captures the operation and keeps it out of the buffer. It then watches the buffer's valid address tags until no buffered store falls in the same cache line, and sends the operation directly to the cache with its opcode.

Only one atomic operation may be outstanding at a time. The core is stalled from the moment the operation is accepted until its result comes back. The cache's reply is passed to the core as a one-cycle response pulse with data. Some operations would touch bytes in two cache lines. These are refused with a one-cycle misalignment flag and never reach the cache. Buffered stores to other lines do not hold the atomic back, so it may overtake them.

Top module: `amo_store_gate`

## Requirements
- R1: After reset, sb_push_valid, c_req_valid, amo_rsp_valid and amo_misalign are all low, and the block is idle.
- R2: In idle, a request with req_amo=0 appears combinationally on the sb_push_* outputs with the same address, data and size. req_ready equals sb_push_ready in that case, and c_req_valid stays low.
- R3: A request with req_amo=1 is never presented to the store buffer (sb_push_valid stays low), and in idle it is accepted with req_ready high.
- R4: An accepted atomic operation is held with c_req_valid low while any sb_tag_valid bit is set whose tag lies in the same line as the operation's address. Two addresses are in the same line when they are equal after their low log2(LINE_BYTES) bits are dropped. c_req_valid rises in the same cycle as the last matching tag valid drops.
- R5: Tags in other lines, and tags in the same line whose valid bit is low, do not delay the operation: c_req_valid is high in the first cycle after acceptance.
- R6: c_req_addr, c_req_data, c_req_op and c_req_size carry the accepted request's fields unchanged and stay stable while c_req_valid is high and c_req_ready is low.
- R7: From acceptance of an atomic operation until the cycle in which amo_rsp_valid is asserted, req_ready and sb_push_valid are low.
- R8: An atomic operation whose line offset plus 2^req_size bytes exceeds LINE_BYTES causes a one-cycle amo_misalign pulse in the cycle after acceptance. The block issues no cache request for it and returns to idle.
- R9: c_rsp_valid while a response is awaited gives a one-cycle amo_rsp_valid pulse in the next cycle, with amo_rsp_data equal to c_rsp_data.
- R10: c_rsp_valid while no response is awaited (idle or holding) has no effect on amo_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can take the request |
| req_amo | input | 1 | 1 = atomic operation, 0 = ordinary store |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | DATA_W | Store data or atomic operand |
| req_op | input | OP_W | Atomic operation code |
| req_size | input | SIZE_W | log2 of access size in bytes |
| sb_push_valid | output | 1 | Store buffer push valid |
| sb_push_ready | input | 1 | Store buffer has room |
| sb_push_addr | output | ADDR_W | Pushed store address |
| sb_push_data | output | DATA_W | Pushed store data |
| sb_push_size | output | SIZE_W | Pushed store size |
| sb_tag_valid | input | SB_DEPTH | Valid bit of each buffered store |
| sb_tag_addr | input | SB_DEPTH*ADDR_W | Address of each buffered store, entry i at bits i*ADDR_W |
| c_req_valid | output | 1 | Atomic request to cache valid |
| c_req_ready | input | 1 | Cache accepts request |
| c_req_addr | output | ADDR_W | Atomic address |
| c_req_data | output | DATA_W | Atomic operand |
| c_req_op | output | OP_W | Atomic operation code |
| c_req_size | output | SIZE_W | Atomic size |
| c_rsp_valid | input | 1 | Cache result valid |
| c_rsp_data | input | DATA_W | Cache result |
| amo_rsp_valid | output | 1 | Result pulse to core |
| amo_rsp_data | output | DATA_W | Result to core |
| amo_misalign | output | 1 | Line-crossing error pulse |

## Verification
The release of a held atomic operation falls in the same cycle as the retirement of the last conflicting buffered store: a tag valid bit drops and c_req_valid must rise without an extra cycle. The bench provokes this by loading the tag model with several same-line entries, some valid and some not, next to entries in other lines. It clears the matching entries one per cycle and checks, right after each change, that the request stays low while any match remains and is high as soon as none does. During the same holding window the bench also offers a store and a stray cache response, and judges that neither gets through.

// File: rtl/amo_store_gate.sv
`timescale 1ns/1ps
module amo_store_gate #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int OP_W       = 5,
  parameter int SIZE_W     = 2,
  parameter int SB_DEPTH   = 8,
  parameter int LINE_BYTES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_amo,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_data,
  input  logic [OP_W-1:0]            req_op,
  input  logic [SIZE_W-1:0]          req_size,
  output logic                       sb_push_valid,
  input  logic                       sb_push_ready,
  output logic [ADDR_W-1:0]          sb_push_addr,
  output logic [DATA_W-1:0]          sb_push_data,
  output logic [SIZE_W-1:0]          sb_push_size,
  input  logic [SB_DEPTH-1:0]        sb_tag_valid,
  input  logic [SB_DEPTH*ADDR_W-1:0] sb_tag_addr,
  output logic                       c_req_valid,
  input  logic                       c_req_ready,
  output logic [ADDR_W-1:0]          c_req_addr,
  output logic [DATA_W-1:0]          c_req_data,
  output logic [OP_W-1:0]            c_req_op,
  output logic [SIZE_W-1:0]          c_req_size,
  input  logic                       c_rsp_valid,
  input  logic [DATA_W-1:0]          c_rsp_data,
  output logic                       amo_rsp_valid,
  output logic [DATA_W-1:0]          amo_rsp_data,
  output logic                       amo_misalign
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));
  localparam logic [OFF_W:0] LINE_LIMIT = (OFF_W+1)'(LINE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_RESP} state_t;

  state_t            state;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic [OP_W-1:0]   hold_op;
  logic [SIZE_W-1:0] hold_size;
  logic [SB_DEPTH-1:0] hit;
  logic [OFF_W:0]    end_off;
  logic              crosses, idle, accept_amo, conflict;

  assign idle          = (state == S_IDLE);
  assign req_ready     = idle && (req_amo || sb_push_ready);
  assign sb_push_valid = idle && req_valid && !req_amo;
  assign sb_push_addr  = req_addr;
  assign sb_push_data  = req_data;
  assign sb_push_size  = req_size;
  assign accept_amo    = idle && req_valid && req_amo;

  assign end_off = {1'b0, req_addr[OFF_W-1:0]} + ((OFF_W+1)'(1) << req_size);
  assign crosses = end_off > LINE_LIMIT;

  for (genvar i = 0; i < SB_DEPTH; i++) begin : g_snoop
    assign hit[i] = sb_tag_valid[i] &&
                    (((sb_tag_addr[i*ADDR_W +: ADDR_W] ^ hold_addr) & LINE_MASK) == '0);
  end
  assign conflict = |hit;

  assign c_req_valid = (state == S_HOLD) && !conflict;
  assign c_req_addr  = hold_addr;
  assign c_req_data  = hold_data;
  assign c_req_op    = hold_op;
  assign c_req_size  = hold_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      hold_addr     <= '0;
      hold_data     <= '0;
      hold_op       <= '0;
      hold_size     <= '0;
      amo_rsp_valid <= 1'b0;
      amo_rsp_data  <= '0;
      amo_misalign  <= 1'b0;
    end else begin
      amo_rsp_valid <= 1'b0;
      amo_misalign  <= 1'b0;
      case (state)
        S_IDLE: if (accept_amo) begin
          if (crosses) begin
            amo_misalign <= 1'b1;
          end else begin
            state     <= S_HOLD;
            hold_addr <= req_addr;
            hold_data <= req_data;
            hold_op   <= req_op;
            hold_size <= req_size;
          end
        end
        S_HOLD: if (c_req_valid && c_req_ready) state <= S_RESP;
        S_RESP: if (c_rsp_valid) begin
          amo_rsp_valid <= 1'b1;
          amo_rsp_data  <= c_rsp_data;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_store_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sb_push_valid |-> !req_amo);

  assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_req_valid && !c_req_ready) |=> (c_req_valid && $stable(c_req_addr) &&
      $stable(c_req_data) && $stable(c_req_op) && $stable(c_req_size)));

  assert_core_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_req_valid |-> (!req_ready && !sb_push_valid));

  assert_misalign_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    amo_misalign |-> ($past(req_valid && req_amo && req_ready) && !c_req_valid));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    amo_rsp_valid |=> !amo_rsp_valid);

endmodule

// File: tb/amo_store_gate_bench.sv
`timescale 1ns/1ps
module amo_store_gate_bench;
  localparam int AW = 32, DW = 64, OW = 5, SW = 2, DEP = 8, LB = 64;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_amo = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_data = 0;
  logic [OW-1:0] req_op = 0;
  logic [SW-1:0] req_size = 0;
  logic req_ready, sb_push_valid, sb_push_ready = 0;
  logic [AW-1:0] sb_push_addr;
  logic [DW-1:0] sb_push_data;
  logic [SW-1:0] sb_push_size;
  logic [DEP-1:0] sb_tag_valid = 0;
  logic [DEP*AW-1:0] sb_tag_addr = 0;
  logic c_req_valid, c_req_ready = 0;
  logic [AW-1:0] c_req_addr;
  logic [DW-1:0] c_req_data;
  logic [OW-1:0] c_req_op;
  logic [SW-1:0] c_req_size;
  logic c_rsp_valid = 0;
  logic [DW-1:0] c_rsp_data = 0;
  logic amo_rsp_valid, amo_misalign;
  logic [DW-1:0] amo_rsp_data;

  int checks = 0, errors = 0;
  bit tv [DEP];
  logic [AW-1:0] ta [DEP];

  always #5 clk = ~clk;

  amo_store_gate u_amo_store_gate (
    .clk, .rst_n, .req_valid, .req_ready, .req_amo, .req_addr, .req_data, .req_op, .req_size,
    .sb_push_valid, .sb_push_ready, .sb_push_addr, .sb_push_data, .sb_push_size,
    .sb_tag_valid, .sb_tag_addr, .c_req_valid, .c_req_ready, .c_req_addr, .c_req_data,
    .c_req_op, .c_req_size, .c_rsp_valid, .c_rsp_data, .amo_rsp_valid, .amo_rsp_data,
    .amo_misalign);

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit crosses(input logic [AW-1:0] a, input logic [SW-1:0] s);
    return (int'(a % LB) + (1 << s)) > LB;
  endfunction

  function automatic bit conflict_exp(input logic [AW-1:0] a);
    for (int i = 0; i < DEP; i++)
      if (tv[i] && (ta[i] / LB) == (a / LB)) return 1;
    return 0;
  endfunction

  task automatic push_tags();
    for (int i = 0; i < DEP; i++) begin
      sb_tag_valid[i] = tv[i];
      sb_tag_addr[i*AW +: AW] = ta[i];
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s, input bit rdy);
    @(negedge clk);
    req_valid = 1; req_amo = 0; req_addr = a; req_data = d; req_size = s; sb_push_ready = rdy;
    #1;
    check("R2", "push_valid", sb_push_valid, 1);
    check("R2", "push_addr", sb_push_addr, a);
    check("R2", "push_data", sb_push_data, d);
    check("R2", "push_size", sb_push_size, s);
    check("R2", "req_ready", req_ready, rdy);
    check("R2", "no cache req", c_req_valid, 0);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_amo(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [OW-1:0] op, input logic [SW-1:0] s);
    logic [DW-1:0] rd;
    @(negedge clk);
    req_valid = 1; req_amo = 1; req_addr = a; req_data = d; req_op = op; req_size = s; sb_push_ready = 1;
    #1;
    check("R3", "amo accepted", req_ready, 1);
    check("R3", "amo not pushed", sb_push_valid, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (crosses(a, s)) begin
      check("R8", "misalign pulse", amo_misalign, 1);
      check("R8", "no cache req", c_req_valid, 0);
      @(negedge clk);
      check("R8", "misalign cleared", amo_misalign, 0);
      check("R8", "still no cache req", c_req_valid, 0);
      check("R8", "back to idle", req_ready, 1);
      return;
    end
    check("R8", "no misalign", amo_misalign, 0);
    if (!conflict_exp(a)) check("R5", "issue next cycle", c_req_valid, 1);
    while (conflict_exp(a)) begin
      check("R4", "held on conflict", c_req_valid, 0);
      req_valid = 1; req_amo = 0; c_rsp_valid = 1; c_rsp_data = 64'hdead;
      #1;
      check("R7", "ready low while held", req_ready, 0);
      check("R7", "no push while held", sb_push_valid, 0);
      @(negedge clk);
      req_valid = 0; req_amo = 1; c_rsp_valid = 0;
      check("R10", "stray rsp ignored in hold", amo_rsp_valid, 0);
      begin
        bit done = 0;
        for (int i = 0; i < DEP; i++)
          if (!done && tv[i] && (ta[i] / LB) == (a / LB)) begin tv[i] = 0; done = 1; end
      end
      push_tags();
      #1;
    end
    check("R4", "released same cycle", c_req_valid, 1);
    check("R6", "addr", c_req_addr, a);
    check("R6", "data", c_req_data, d);
    check("R6", "op", c_req_op, op);
    check("R6", "size", c_req_size, s);
    repeat ($urandom % 3) begin
      @(negedge clk);
      check("R6", "valid held", c_req_valid, 1);
      check("R6", "addr held", c_req_addr, a);
    end
    c_req_ready = 1;
    @(posedge clk);
    @(negedge clk);
    c_req_ready = 0;
    check("R6", "valid drops after handshake", c_req_valid, 0);
    check("R7", "ready low awaiting rsp", req_ready, 0);
    repeat ($urandom % 3) @(negedge clk);
    rd = {$urandom, $urandom};
    c_rsp_valid = 1; c_rsp_data = rd;
    @(posedge clk);
    @(negedge clk);
    c_rsp_valid = 0;
    check("R9", "rsp valid", amo_rsp_valid, 1);
    check("R9", "rsp data", amo_rsp_data, rd);
    check("R7", "ready returns with rsp", req_ready, 1);
    @(negedge clk);
    check("R9", "rsp pulse one cycle", amo_rsp_valid, 0);
  endtask

  task automatic rand_tags(input logic [AW-1:0] a);
    for (int i = 0; i < DEP; i++) begin
      tv[i] = 1'($urandom);
      if ($urandom % 3 == 0) ta[i] = {a[AW-1:6], 6'($urandom)};
      else ta[i] = {a[AW-1:6] ^ (26'($urandom) | 26'h1), 6'($urandom)};
    end
    push_tags();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEP; i++) begin tv[i] = 0; ta[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "push_valid", sb_push_valid, 0);
    check("R1", "c_req_valid", c_req_valid, 0);
    check("R1", "rsp_valid", amo_rsp_valid, 0);
    check("R1", "misalign", amo_misalign, 0);

    c_rsp_valid = 1;
    @(negedge clk);
    c_rsp_valid = 0;
    @(negedge clk);
    check("R10", "stray rsp ignored in idle", amo_rsp_valid, 0);

    do_store(32'h1000, 64'h11, 2'd3, 1);
    do_store(32'h1040, 64'h22, 2'd0, 0);

    for (int i = 0; i < DEP; i++) begin tv[i] = 0; ta[i] = 32'h2000 + 32'(i); end
    tv[1] = 0; tv[5] = 1; ta[5] = 32'h9000;
    push_tags();
    do_amo(32'h2008, 64'hA5, 5'd3, 2'd3);

    tv[0] = 1; tv[2] = 1; tv[4] = 1; ta[4] = 32'h303f;
    ta[0] = 32'h3000; ta[2] = 32'h3010;
    push_tags();
    do_amo(32'h3020, 64'h5A, 5'd7, 2'd2);

    for (int i = 0; i < DEP; i++) tv[i] = 0;
    push_tags();
    do_amo(32'h403c, 64'h1, 5'd1, 2'd2);
    do_amo(32'h403d, 64'h2, 5'd1, 2'd2);
    do_amo(32'h407f, 64'h3, 5'd2, 2'd0);

    for (int n = 0; n < 150; n++) begin
      logic [AW-1:0] a = $urandom;
      logic [SW-1:0] s = 2'($urandom);
      if ($urandom % 2 == 0) begin
        do_store(a, {$urandom, $urandom}, s, 1'($urandom));
      end else begin
        rand_tags(a);
        do_amo(a, {$urandom, $urandom}, 5'($urandom), s);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule